// File: doc/BRIEF.md
# Pen-Interrupt Trigger Rate Limiter

A touch-panel front end raises a level-shifted pen-down signal, but that signal is corrupted whenever other analog channels are being converted. This block turns the pen-down signal into a paced stream of one-cycle sample triggers. While triggers are being produced, it masks the pen input. It limits trigger issue to one per programmed scan interval. After the last pen-down edge, it keeps polling for a bounded number of intervals and then drops back to an interrupt-driven idle state to save power.

A scan engine downstream consumes `trigger_o` and reports back with `scan_done_i` when it has finished. The interval and the scan length are both given in clock cycles. The wait after a scan equals the interval minus the scan length. The `irq_mask_o` output drives the interrupt-mask control of the pen-down source.

States are: off (after reset and after disable), idle (waiting for a pen edge), armed (a trigger has been issued and the block waits for the scan and then the pause), and two polling waits. The first polling wait keeps the pen masked. The second polling wait, used once the minimum poll count is reached, lets a fresh pen edge restart the sequence.

Top module: `pen_trig_limiter`

## Requirements
- R1: After reset the block is off: `irq_mask_o`=1 and `trigger_o`=0. While it is off, no pen activity and no `scan_done_i` produces a trigger.
- R2: `enable_i` while off moves the block to idle, and `irq_mask_o` reads 0 after that clock edge. `enable_i` in any other state has no effect.
- R3: `disable_i` has top priority in any state. It sets `irq_mask_o`=1, stops the timer, and returns the block to off, so no further trigger appears until the block is enabled and sees a new pen edge.
- R4: A rising pen edge, seen while unmasked and not off, is acted on at the third clock edge after `pen_irq_i` rises. At that edge `trigger_o` pulses for one cycle, `irq_mask_o` goes to 1, the poll count clears and the timer stops.
- R5: `scan_done_i` in the armed state starts a pause of L = `interval_i` − `scan_len_i` cycles. The expiry takes effect at the (L+1)-th clock edge after the edge that sampled `scan_done_i`.
- R6: When the pause expires in the armed state and the poll count is below 6, the count increments and a full interval (`interval_i`+1 edges) is started. If the new count is 3 or more, the block enters the unmasked poll wait and `irq_mask_o` goes to 0. Otherwise it enters the masked poll wait and the mask stays at 1.
- R7: Expiry of a poll wait issues one trigger and returns the block to armed. Leaving the unmasked wait this way sets `irq_mask_o` back to 1. Two triggers are never issued on consecutive cycles.
- R8: When the pause expires in the armed state with the poll count at 6, the block enters idle with `irq_mask_o`=0. One pen edge with regular scan completions therefore yields exactly 7 triggers.
- R9: `scan_done_i` outside the armed state is ignored.
- R10: Only rising edges count. A pen input held high, or an edge that arrives while masked, issues no trigger.
- R11: If `scan_len_i` ≥ `interval_i`, the pause L saturates at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pen_irq_i | input | 1 | Asynchronous pen-down level |
| enable_i | input | 1 | One-cycle request to leave the off state |
| disable_i | input | 1 | One-cycle request to enter the off state |
| scan_done_i | input | 1 | One-cycle pulse: triggered scan finished |
| interval_i | input | TW | Scan interval in cycles |
| scan_len_i | input | TW | Scan duration in cycles |
| irq_mask_o | output | 1 | 1 = pen-down source masked |
| trigger_o | output | 1 | One-cycle sample trigger |

## Verification
The hardest situation to reach is the last step of a long poll window. That step requires seven triggers in a row, each answered by a scan completion and each followed by its pause and interval, with the pen held high throughout so that no fresh edge restarts the count. The bench holds the pen high, runs an automatic scan responder that answers every trigger one cycle later, and then checks the trigger count, the spacing of the triggers, and the final unmask. A long seeded random phase then mixes pen toggles, stray completions and enable/disable requests against a cycle-level reference model. This phase covers pen edges that land inside the unmasked poll wait.

// File: rtl/ptl_pkg.sv
// Package: shared state encoding for the pen trigger rate limiter.
// Assumes: only the control FSM writes the state; other units only read it.
package ptl_pkg;
    typedef enum logic [2:0] {
        ST_OFF         = 3'd0,  // powered down, pen masked
        ST_IDLE        = 3'd1,  // waiting for pen edge, unmasked
        ST_WAIT_MASKED = 3'd2,  // poll wait, pen stays masked
        ST_WAIT_OPEN   = 3'd3,  // poll wait, pen unmasked
        ST_ARMED       = 3'd4   // trigger issued, waiting scan/pause
    } ptl_state_e;
endpackage

// File: rtl/ptl_pen_sync.sv
// Module: ptl_pen_sync
// Synchronizes the asynchronous pen level through STAGES flops and flags
// its rising edge for one cycle.
// Assumes: the pen level is slow compared with the clock.
module ptl_pen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            // Purpose: single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_many
            // Purpose: multi-flop capture chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    // Purpose: remember last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ptl_interval_timer.sv
// Module: ptl_interval_timer
// One-shot down counter. A load of value L makes expire_o high in the
// cycle after L further edges, so the consumer acts at edge L+1.
// A load has priority over a cancel. Expiry stops the timer unless it is reloaded.
// Assumes: load and cancel are single-cycle commands from the FSM.
module ptl_interval_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    input  logic          cancel_i,
    output logic          expire_o
);
    logic [TW-1:0] cnt_q;
    logic          run_q;

    assign expire_o = run_q && (cnt_q == '0);

    // Purpose: count down and track whether the timer is running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
            run_q <= 1'b1;
        end else if (cancel_i || expire_o) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/ptl_ctrl.sv
// Module: ptl_ctrl
// Control FSM: mask control, trigger generation, poll counting and timer
// commands. Priority per cycle is disable, pen edge, enable, scan done,
// then timer expiry.
// Assumes: pen_rise_i is already synchronized; expire_i comes from a
// timer that this module commands.
module ptl_ctrl
    import ptl_pkg::*;
#(
    parameter int TW          = 20,
    parameter int MIN_POLLS   = 3,
    parameter int EXTRA_POLLS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pen_rise_i,
    input  logic          enable_i,
    input  logic          disable_i,
    input  logic          scan_done_i,
    input  logic          expire_i,
    input  logic [TW-1:0] interval_i,
    input  logic [TW-1:0] scan_len_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          tmr_cancel_o,
    output logic          mask_o,
    output logic          trigger_o,
    output ptl_state_e    state_o
);
    localparam int TOTAL_POLLS = MIN_POLLS + EXTRA_POLLS;
    localparam int PCW = $clog2(TOTAL_POLLS + 1);
    localparam logic [PCW-1:0] TOTAL_C = PCW'(TOTAL_POLLS);
    localparam logic [PCW-1:0] MIN_C   = PCW'(MIN_POLLS);

    ptl_state_e     state_q, state_d;
    logic [PCW-1:0] pc_q, pc_d, pc_inc;
    logic           mask_q, mask_d;
    logic           trig_q, trig_d;
    logic [TW-1:0]  rest_delay;
    logic           pen_evt;

    // Purpose: pause after a scan, saturating at zero
    always_comb begin
        if (interval_i > scan_len_i) rest_delay = interval_i - scan_len_i;
        else                         rest_delay = '0;
    end

    assign pc_inc  = pc_q + 1'b1;
    assign pen_evt = pen_rise_i && !mask_q && (state_q != ST_OFF);

    // Purpose: next-state, mask, trigger and timer command decoding
    always_comb begin
        state_d      = state_q;
        pc_d         = pc_q;
        mask_d       = mask_q;
        trig_d       = 1'b0;
        tmr_load_o   = 1'b0;
        tmr_cancel_o = 1'b0;
        tmr_val_o    = interval_i;
        if (disable_i) begin
            state_d      = ST_OFF;
            mask_d       = 1'b1;
            tmr_cancel_o = 1'b1;
        end else if (pen_evt) begin
            state_d      = ST_ARMED;
            pc_d         = '0;
            mask_d       = 1'b1;
            trig_d       = 1'b1;
            tmr_cancel_o = 1'b1;
        end else if (enable_i && state_q == ST_OFF) begin
            state_d = ST_IDLE;
            mask_d  = 1'b0;
        end else if (scan_done_i && state_q == ST_ARMED) begin
            tmr_load_o = 1'b1;
            tmr_val_o  = rest_delay;
        end else if (expire_i) begin
            unique case (state_q)
                ST_ARMED: begin
                    if (pc_q < TOTAL_C) begin
                        pc_d       = pc_inc;
                        tmr_load_o = 1'b1;
                        if (pc_inc >= MIN_C) begin
                            state_d = ST_WAIT_OPEN;
                            mask_d  = 1'b0;
                        end else begin
                            state_d = ST_WAIT_MASKED;
                        end
                    end else begin
                        state_d = ST_IDLE;
                        mask_d  = 1'b0;
                    end
                end
                ST_WAIT_OPEN: begin
                    mask_d  = 1'b1;
                    state_d = ST_ARMED;
                    trig_d  = 1'b1;
                end
                ST_WAIT_MASKED: begin
                    state_d = ST_ARMED;
                    trig_d  = 1'b1;
                end
                default: begin
                    state_d = state_q;
                end
            endcase
        end
    end

    // Purpose: state, poll count, mask and trigger registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            pc_q    <= '0;
            mask_q  <= 1'b1;
            trig_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            mask_q  <= mask_d;
            trig_q  <= trig_d;
        end
    end

    assign mask_o    = mask_q;
    assign trigger_o = trig_q;
    assign state_o   = state_q;
endmodule

// File: rtl/pen_trig_limiter.sv
// Module: pen_trig_limiter (top)
// Turns a pen-down level into paced sample triggers, masking the pen
// source while polling and falling back to idle after a bounded window.
// Assumes: interval_i and scan_len_i are in clock cycles and held stable
// while a pause is running.
module pen_trig_limiter
    import ptl_pkg::*;
#(
    parameter int TW          = 20,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_POLLS   = 3,
    parameter int EXTRA_POLLS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pen_irq_i,
    input  logic          enable_i,
    input  logic          disable_i,
    input  logic          scan_done_i,
    input  logic [TW-1:0] interval_i,
    input  logic [TW-1:0] scan_len_i,
    output logic          irq_mask_o,
    output logic          trigger_o
);
    logic          pen_rise;
    logic          tmr_load;
    logic          tmr_cancel;
    logic          tmr_expire;
    logic [TW-1:0] tmr_val;
    ptl_state_e    state_q;

    ptl_pen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pen_irq_i),
        .rise_o  (pen_rise)
    );

    ptl_interval_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .cancel_i   (tmr_cancel),
        .expire_o   (tmr_expire)
    );

    ptl_ctrl #(
        .TW          (TW),
        .MIN_POLLS   (MIN_POLLS),
        .EXTRA_POLLS (EXTRA_POLLS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pen_rise_i   (pen_rise),
        .enable_i     (enable_i),
        .disable_i    (disable_i),
        .scan_done_i  (scan_done_i),
        .expire_i     (tmr_expire),
        .interval_i   (interval_i),
        .scan_len_i   (scan_len_i),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .tmr_cancel_o (tmr_cancel),
        .mask_o       (irq_mask_o),
        .trigger_o    (trigger_o),
        .state_o      (state_q)
    );
endmodule

// File: rtl/ptl_checks.sv
// Module: ptl_checks
// Property checker bound to pen_trig_limiter.
// Assumes: the state and timer expiry nets of the top are visible by name.
module ptl_checks
    import ptl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       enable_i,
    input logic       disable_i,
    input logic       trigger_o,
    input logic       irq_mask_o,
    input logic [2:0] state_q,
    input logic       tmr_expire
);
    assert_trig_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trigger_o |-> irq_mask_o);

    assert_trig_spaced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trigger_o |=> !trigger_o);

    assert_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> (irq_mask_o && !trigger_o && state_q == ST_OFF));

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !enable_i) |=> (state_q == ST_OFF && !trigger_o));

    assert_unmask_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_mask_o) |-> ($past(enable_i) || $past(tmr_expire)));

    assert_idle_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !irq_mask_o);
endmodule

bind pen_trig_limiter ptl_checks u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .disable_i  (disable_i),
    .trigger_o  (trigger_o),
    .irq_mask_o (irq_mask_o),
    .state_q    (state_q),
    .tmr_expire (tmr_expire)
);

// File: tb/pen_trig_limiter_tb.sv
module pen_trig_limiter_tb;
    localparam int TW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pen_irq_i = 1'b0;
    logic          enable_i = 1'b0;
    logic          disable_i = 1'b0;
    logic          scan_done_i = 1'b0;
    logic [TW-1:0] interval_i = 20'd40;
    logic [TW-1:0] scan_len_i = 20'd15;
    logic          irq_mask_o;
    logic          trigger_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int trig_cnt = 0;
    int t_prev = 0;
    int t_last = 0;
    bit auto_done = 1'b0;
    bit finished = 1'b0;

    pen_trig_limiter #(.TW(TW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pen_irq_i   (pen_irq_i),
        .enable_i    (enable_i),
        .disable_i   (disable_i),
        .scan_done_i (scan_done_i),
        .interval_i  (interval_i),
        .scan_len_i  (scan_len_i),
        .irq_mask_o  (irq_mask_o),
        .trigger_o   (trigger_o)
    );

    always #10 clk = ~clk;

    // Reference model built from the requirements.
    // Model state encoding: 0 off, 1 idle, 2 masked wait, 3 open wait, 4 armed.
    int   m_st, m_pc, m_tc, m_tag;
    bit   m_run, m_mask, m_trig, m_s1, m_s2, m_s3;
    bit   ex, rs;
    int   rest;

    function automatic int pause_len(input int iv, input int sl);
        return (iv > sl) ? iv - sl : 0;   // R11 saturation
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_pc <= 0; m_tc <= 0; m_run <= 0;
            m_mask <= 1; m_trig <= 0; m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_tag <= 1;
        end else begin
            ex = m_run && (m_tc == 0);
            rs = m_s2 && !m_s3;
            rest = pause_len(int'(interval_i), int'(scan_len_i));
            m_s1 <= pen_irq_i; m_s2 <= m_s1; m_s3 <= m_s2;
            m_trig <= 0;
            if (m_run && m_tc != 0) m_tc <= m_tc - 1;
            if (ex) m_run <= 0;
            if (disable_i) begin
                m_st <= 0; m_mask <= 1; m_run <= 0; m_tag <= 3;
            end else if (rs && !m_mask && m_st != 0) begin
                m_st <= 4; m_pc <= 0; m_mask <= 1; m_trig <= 1; m_run <= 0; m_tag <= 4;
            end else if (enable_i && m_st == 0) begin
                m_st <= 1; m_mask <= 0; m_tag <= 2;
            end else if (scan_done_i && m_st == 4) begin
                m_run <= 1; m_tc <= rest; m_tag <= (rest == 0) ? 11 : 5;
            end else if (ex) begin
                if (m_st == 4) begin
                    if (m_pc < 6) begin
                        m_pc <= m_pc + 1; m_run <= 1; m_tc <= int'(interval_i); m_tag <= 6;
                        if (m_pc + 1 >= 3) begin m_st <= 3; m_mask <= 0; end
                        else m_st <= 2;
                    end else begin
                        m_st <= 1; m_mask <= 0; m_tag <= 8;
                    end
                end else if (m_st == 3 || m_st == 2) begin
                    m_mask <= 1; m_st <= 4; m_trig <= 1; m_tag <= 7;
                end
            end else if (scan_done_i) begin
                m_tag <= 9;
            end
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // One clock: compare with model at negedge, record triggers, drive responder.
    task automatic tick();
        @(negedge clk);
        cyc++;
        enable_i = 1'b0;
        disable_i = 1'b0;
        if (rst_n) begin
            checks++;
            if (trigger_o !== m_trig || irq_mask_o !== m_mask) begin
                errors++;
                $display("FAIL R%0d: actual trig=%0b mask=%0b expected trig=%0b mask=%0b (cycle %0d)",
                         m_tag, trigger_o, irq_mask_o, m_trig, m_mask, cyc);
            end
        end
        if (trigger_o === 1'b1) begin
            trig_cnt++;
            t_prev = t_last;
            t_last = cyc;
        end
        scan_done_i = auto_done && (trigger_o === 1'b1);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ticks(3);
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        int base;
        do_reset();
        // R1: reset state
        check(trigger_o == 1'b0, "R1 trigger after reset", trigger_o, 0);
        check(irq_mask_o == 1'b1, "R1 mask after reset", irq_mask_o, 1);

        // R1/R10: pen edge while off is ignored
        base = trig_cnt;
        pen_irq_i = 1'b1; ticks(4); pen_irq_i = 1'b0; ticks(4);
        scan_done_i = 1'b1; ticks(10);
        check(trig_cnt == base, "R1 no trigger while off", trig_cnt - base, 0);

        // R2: enable unmasks
        enable_i = 1'b1; tick();
        check(irq_mask_o == 1'b0, "R2 mask after enable", irq_mask_o, 0);
        enable_i = 1'b1; tick();
        check(irq_mask_o == 1'b0, "R2 second enable no effect", irq_mask_o, 0);

        // R9: stray scan completion in idle
        base = trig_cnt;
        scan_done_i = 1'b1; ticks(100);
        check(trig_cnt == base, "R9 done in idle ignored", trig_cnt - base, 0);

        // R4: pen edge acted on at third edge
        auto_done = 1'b1;
        base = trig_cnt;
        pen_irq_i = 1'b1;
        ticks(2);
        check(trigger_o == 1'b0, "R4 no trigger before third edge", trigger_o, 0);
        tick();
        check(trigger_o == 1'b1, "R4 trigger at third edge", trigger_o, 1);
        check(irq_mask_o == 1'b1, "R4 mask with trigger", irq_mask_o, 1);
        tick();
        tick();
        check(t_last - t_prev == 0 || trig_cnt - base == 1, "R4 single trigger", trig_cnt - base, 1);
        ticks(70);
        // R5: gap = (40-15) + 40 + 3
        check(t_last - t_prev == 68, "R5 trigger spacing", t_last - t_prev, 68);
        check(irq_mask_o == 1'b1, "R6 masked during early polls", irq_mask_o, 1);
        ticks(600);
        // R8: seven triggers then idle unmasked
        check(trig_cnt - base == 7, "R8 burst length", trig_cnt - base, 7);
        check(irq_mask_o == 1'b0, "R8 idle unmasked", irq_mask_o, 0);
        // R10: held-high pen does not retrigger
        base = trig_cnt;
        ticks(200);
        check(trig_cnt == base, "R10 held pen no retrigger", trig_cnt - base, 0);

        // R3: disable in the middle of polling
        pen_irq_i = 1'b0; ticks(4); pen_irq_i = 1'b1; ticks(150);
        disable_i = 1'b1; tick();
        check(irq_mask_o == 1'b1, "R3 mask after disable", irq_mask_o, 1);
        base = trig_cnt;
        ticks(300);
        check(trig_cnt == base, "R3 no trigger after disable", trig_cnt - base, 0);

        // R11: scan longer than interval, pause saturates
        scan_len_i = 20'd60;
        pen_irq_i = 1'b0;
        enable_i = 1'b1; tick();
        ticks(3);
        pen_irq_i = 1'b1;
        ticks(50);
        check(t_last - t_prev == 43, "R11 saturated spacing", t_last - t_prev, 43);

        // Seeded random phase against the model
        void'($urandom(32'd1234));
        for (int i = 0; i < 6000; i++) begin
            if (i % 500 == 0) begin
                interval_i = TW'(3 + ($urandom % 28));
                scan_len_i = TW'($urandom % 41);
            end
            tick();
            if ($urandom % 30 == 0) pen_irq_i = ~pen_irq_i;
            if ($urandom % 200 == 0) enable_i = 1'b1;
            if ($urandom % 400 == 0) disable_i = 1'b1;
            if ($urandom % 50 == 0) scan_done_i = 1'b1;
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule